// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial-peripheral-bus slave that lets a host program a small bank of configuration registers and reach a second, parallel register bus through an indirect window. A mode input decides where the host's serial lines go. When the mode input is 1, every 16-bit command frame is decoded locally, and the lines toward the data converter are parked so the converter sees nothing. When it is 0, the host's clock, select and data lines pass straight to the converter and its returned data passes straight back.

A frame carries a 3-bit register number in its top bits, a direction bit below it (1 writes, 0 reads), and 12 data bits at the bottom. Four registers drive configuration fields to the rest of the chip. Two registers report live status: a frequency count and a pair of test flags. Two registers form the indirect path. The first holds a 7-bit bus address and a direction bit. The second moves one data word across the parallel bus.

The serial inputs are oversampled by the system clock through a synchronizer. Because of this, the serial clock must run several times slower than the system clock.

Top module: `cfgspi_top`

## Requirements
- R1: A complete 16-bit write frame (bits 15..13 register number, bit 12 = 1, bits 11..0 data) to register 0, 1, 2 or 3 loads the low 10, 3, 7 or 2 data bits into presamples_o, size_code_o, led_o or tp_send_o respectively. Those outputs change only on such a write.
- R2: In a read frame (bit 12 = 0), MISO carries 0 during the four header bits. It then carries the addressed register's 12-bit value, most significant bit first, and changes only after falling serial clock edges. Register bits above a field's width read as 0.
- R3: A frame whose chip select (active low) rises before the 16th rising serial clock edge changes no register and produces no strobe.
- R4: With cfg_sel_i = 0, adc_sclk_o, adc_cs_n_o and adc_mosi_o follow the host lines, spi_miso_o follows adc_miso_i, and frames change no register. With cfg_sel_i = 1, adc_cs_n_o is held at 1 and adc_sclk_o and adc_mosi_o at 0.
- R5: Reading register 4 returns freq_count_i, and reading register 5 returns tp_flags_i in bits 1..0. A write to register 4 has no effect.
- R6: Any write to register 5 raises flag_rearm_o for exactly one system clock cycle. A read of register 5 does not raise it.
- R7: A write to register 6 stores bits 6..0 as pbus_addr_o and bit 7 as the indirect direction. Reading register 6 returns {direction, address}. When bit 7 is 0, the write raises pbus_rd_o for one cycle with pbus_addr_o already holding the new address, and pbus_rdata_i is captured in that cycle.
- R8: A write to register 7 while the stored direction is 1 raises pbus_wr_o for one cycle, with pbus_wdata_o holding the low PB_DW data bits. While the stored direction is 0, a write to register 7 raises no strobe.
- R9: Reading register 7 returns the word captured by the most recent indirect read, zero-extended.
- R10: After reset, all configuration fields, the indirect address, the strobes and spi_miso_o (with cfg_sel_i = 1) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel_i | input | 1 | 1 = decode frames locally, 0 = pass through to converter |
| spi_sclk_i | input | 1 | Host serial clock |
| spi_cs_n_i | input | 1 | Host chip select, active low |
| spi_mosi_i | input | 1 | Host data toward slave |
| spi_miso_o | output | 1 | Data toward host |
| adc_sclk_o | output | 1 | Serial clock toward converter |
| adc_cs_n_o | output | 1 | Chip select toward converter |
| adc_mosi_o | output | 1 | Data toward converter |
| adc_miso_i | input | 1 | Data from converter |
| freq_count_i | input | 12 | Measured frequency count |
| tp_flags_i | input | 2 | Test-pattern status flags |
| presamples_o | output | 10 | Presample count field |
| size_code_o | output | 3 | Event size code field |
| led_o | output | 7 | Indicator control field |
| tp_send_o | output | 2 | Test-pattern send control field |
| flag_rearm_o | output | 1 | One-cycle pulse re-arming the test flags |
| pbus_addr_o | output | 7 | Indirect bus address |
| pbus_wr_o | output | 1 | Indirect bus write strobe |
| pbus_rd_o | output | 1 | Indirect bus read strobe |
| pbus_wdata_o | output | PB_DW | Indirect bus write data |
| pbus_rdata_i | input | PB_DW | Indirect bus read data |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and an 8-bit indirect data word. It drives the serial clock with a half period of six system clocks. The 8-bit word means register 7 writes whose upper data bits are set show truncation, and register 7 reads show zero-extension to 12 bits. Six system clocks per half period leave room for the three-register path from pin to decoded edge. This margin lets the bench sample MISO just before each rising edge and confirm that the value settled after the previous falling edge. With a 7-bit address, random indirect accesses cover the full 128-entry device model.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
    localparam int FRAME_BITS = 16;
    localparam int HDR_BITS   = 4;
    localparam int DATA_BITS  = 12;
    localparam int RA_BITS    = 3;
    localparam int CNT_BITS   = $clog2(FRAME_BITS + 1);
    localparam int PRESAMP_W  = 10;
    localparam int SIZE_W     = 3;
    localparam int LED_W      = 7;
    localparam int TPS_W      = 2;
    localparam int PB_AW      = 7;
    localparam int FLAG_W     = 2;

    typedef enum logic [RA_BITS-1:0] {
        RA_PRESAMP = 3'd0,
        RA_SIZE    = 3'd1,
        RA_LED     = 3'd2,
        RA_TPSEND  = 3'd3,
        RA_FREQ    = 3'd4,
        RA_FLAGS   = 3'd5,
        RA_PBADDR  = 3'd6,
        RA_PBDATA  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfgspi_frame.sv
module cfgspi_frame
    import cfgspi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 sclk_i,
    input  logic                 cs_n_i,
    input  logic                 mosi_i,
    input  logic [DATA_BITS-1:0] rd_data_i,
    output logic [RA_BITS-1:0]   rd_addr_o,
    output logic                 wr_stb_o,
    output logic [RA_BITS-1:0]   wr_addr_o,
    output logic [DATA_BITS-1:0] wr_data_o,
    output logic                 miso_o
);
    typedef struct packed {
        logic                  sclk_prev;
        logic [FRAME_BITS-1:0] rx;
        logic [CNT_BITS-1:0]   cnt;
        logic [DATA_BITS-1:0]  tx;
        logic                  rd_mode;
        logic                  miso;
        logic                  wr_stb;
        logic [RA_BITS-1:0]    wr_addr;
        logic [DATA_BITS-1:0]  wr_data;
    } frame_t;

    frame_t st_d, st_q;
    logic                  rise, fall;
    logic [FRAME_BITS-1:0] rx_next;

    assign rise      = sclk_i & ~st_q.sclk_prev;
    assign fall      = ~sclk_i & st_q.sclk_prev;
    assign rx_next   = {st_q.rx[FRAME_BITS-2:0], mosi_i};
    // header bits so far plus the bit arriving now form the register number
    assign rd_addr_o = rx_next[RA_BITS:1];

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_i;
        st_d.wr_stb    = 1'b0;
        if (!en_i || cs_n_i) begin
            st_d.cnt     = '0;
            st_d.rd_mode = 1'b0;
            st_d.miso    = 1'b0;
        end else begin
            if (rise && st_q.cnt < CNT_BITS'(FRAME_BITS)) begin
                st_d.rx  = rx_next;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_BITS'(HDR_BITS - 1)) begin
                    st_d.rd_mode = ~mosi_i;
                    st_d.tx      = rd_data_i;
                end
                if (st_q.cnt == CNT_BITS'(FRAME_BITS - 1) && rx_next[DATA_BITS]) begin
                    st_d.wr_stb  = 1'b1;
                    st_d.wr_addr = rx_next[FRAME_BITS-1 -: RA_BITS];
                    st_d.wr_data = rx_next[DATA_BITS-1:0];
                end
            end
            if (fall) begin
                if (st_q.rd_mode) begin
                    {st_d.miso, st_d.tx} = {st_q.tx, 1'b0};
                end else begin
                    st_d.miso = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_stb_o  = st_q.wr_stb;
    assign wr_addr_o = st_q.wr_addr;
    assign wr_data_o = st_q.wr_data;
    assign miso_o    = st_q.miso;
endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
    import cfgspi_pkg::*;
#(
    parameter int PB_DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb_i,
    input  logic [RA_BITS-1:0]   wr_addr_i,
    input  logic [DATA_BITS-1:0] wr_data_i,
    input  logic [RA_BITS-1:0]   rd_addr_i,
    output logic [DATA_BITS-1:0] rd_data_o,
    input  logic [DATA_BITS-1:0] freq_count_i,
    input  logic [FLAG_W-1:0]    tp_flags_i,
    output logic [PRESAMP_W-1:0] presamples_o,
    output logic [SIZE_W-1:0]    size_code_o,
    output logic [LED_W-1:0]     led_o,
    output logic [TPS_W-1:0]     tp_send_o,
    output logic                 flag_rearm_o,
    output logic [PB_AW-1:0]     pbus_addr_o,
    output logic                 pbus_wr_o,
    output logic                 pbus_rd_o,
    output logic [PB_DW-1:0]     pbus_wdata_o,
    input  logic [PB_DW-1:0]     pbus_rdata_i
);
    localparam int DIR_BIT = PB_AW;

    typedef struct packed {
        logic [PRESAMP_W-1:0] presamp;
        logic [SIZE_W-1:0]    size;
        logic [LED_W-1:0]     led;
        logic [TPS_W-1:0]     tps;
        logic [PB_AW-1:0]     pb_addr;
        logic                 pb_dir;
        logic [PB_DW-1:0]     pb_rdata;
        logic [PB_DW-1:0]     pb_wdata;
        logic                 pb_wr;
        logic                 pb_rd;
        logic                 rearm;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d       = rg_q;
        rg_d.pb_wr = 1'b0;
        rg_d.pb_rd = 1'b0;
        rg_d.rearm = 1'b0;
        if (rg_q.pb_rd) rg_d.pb_rdata = pbus_rdata_i;
        if (wr_stb_i) begin
            case (reg_addr_e'(wr_addr_i))
                RA_PRESAMP: rg_d.presamp = wr_data_i[PRESAMP_W-1:0];
                RA_SIZE:    rg_d.size    = wr_data_i[SIZE_W-1:0];
                RA_LED:     rg_d.led     = wr_data_i[LED_W-1:0];
                RA_TPSEND:  rg_d.tps     = wr_data_i[TPS_W-1:0];
                RA_FLAGS:   rg_d.rearm   = 1'b1;
                RA_PBADDR: begin
                    rg_d.pb_addr = wr_data_i[PB_AW-1:0];
                    rg_d.pb_dir  = wr_data_i[DIR_BIT];
                    rg_d.pb_rd   = ~wr_data_i[DIR_BIT];
                end
                RA_PBDATA: begin
                    if (rg_q.pb_dir) begin
                        rg_d.pb_wr    = 1'b1;
                        rg_d.pb_wdata = wr_data_i[PB_DW-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr_e'(rd_addr_i))
            RA_PRESAMP: rd_data_o = DATA_BITS'(rg_q.presamp);
            RA_SIZE:    rd_data_o = DATA_BITS'(rg_q.size);
            RA_LED:     rd_data_o = DATA_BITS'(rg_q.led);
            RA_TPSEND:  rd_data_o = DATA_BITS'(rg_q.tps);
            RA_FREQ:    rd_data_o = freq_count_i;
            RA_FLAGS:   rd_data_o = DATA_BITS'(tp_flags_i);
            RA_PBADDR:  rd_data_o = DATA_BITS'({rg_q.pb_dir, rg_q.pb_addr});
            default:    rd_data_o = DATA_BITS'(rg_q.pb_rdata);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign presamples_o = rg_q.presamp;
    assign size_code_o  = rg_q.size;
    assign led_o        = rg_q.led;
    assign tp_send_o    = rg_q.tps;
    assign flag_rearm_o = rg_q.rearm;
    assign pbus_addr_o  = rg_q.pb_addr;
    assign pbus_wr_o    = rg_q.pb_wr;
    assign pbus_rd_o    = rg_q.pb_rd;
    assign pbus_wdata_o = rg_q.pb_wdata;
endmodule

// File: rtl/cfgspi_top.sv
module cfgspi_top
    import cfgspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PB_DW       = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_sel_i,
    input  logic                 spi_sclk_i,
    input  logic                 spi_cs_n_i,
    input  logic                 spi_mosi_i,
    output logic                 spi_miso_o,
    output logic                 adc_sclk_o,
    output logic                 adc_cs_n_o,
    output logic                 adc_mosi_o,
    input  logic                 adc_miso_i,
    input  logic [11:0]          freq_count_i,
    input  logic [1:0]           tp_flags_i,
    output logic [9:0]           presamples_o,
    output logic [2:0]           size_code_o,
    output logic [6:0]           led_o,
    output logic [1:0]           tp_send_o,
    output logic                 flag_rearm_o,
    output logic [6:0]           pbus_addr_o,
    output logic                 pbus_wr_o,
    output logic                 pbus_rd_o,
    output logic [PB_DW-1:0]     pbus_wdata_o,
    input  logic [PB_DW-1:0]     pbus_rdata_i
);
    logic [3:0]           sync_q;
    logic                 wr_stb;
    logic [RA_BITS-1:0]   wr_addr;
    logic [DATA_BITS-1:0] wr_data;
    logic [RA_BITS-1:0]   rd_addr;
    logic [DATA_BITS-1:0] rd_data;
    logic                 frame_miso;

    cfgspi_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (4),
        .RST_VAL (4'b0100)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cfg_sel_i, spi_cs_n_i, spi_sclk_i, spi_mosi_i}),
        .q_o   (sync_q)
    );

    cfgspi_frame frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (sync_q[3]),
        .sclk_i    (sync_q[1]),
        .cs_n_i    (sync_q[2]),
        .mosi_i    (sync_q[0]),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_stb_o  (wr_stb),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .miso_o    (frame_miso)
    );

    cfgspi_regs #(.PB_DW(PB_DW)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb_i     (wr_stb),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .freq_count_i (freq_count_i),
        .tp_flags_i   (tp_flags_i),
        .presamples_o (presamples_o),
        .size_code_o  (size_code_o),
        .led_o        (led_o),
        .tp_send_o    (tp_send_o),
        .flag_rearm_o (flag_rearm_o),
        .pbus_addr_o  (pbus_addr_o),
        .pbus_wr_o    (pbus_wr_o),
        .pbus_rd_o    (pbus_rd_o),
        .pbus_wdata_o (pbus_wdata_o),
        .pbus_rdata_i (pbus_rdata_i)
    );

    // route host lines: local decode parks the converter side
    assign spi_miso_o = cfg_sel_i ? frame_miso : adc_miso_i;
    assign adc_cs_n_o = cfg_sel_i | spi_cs_n_i;
    assign adc_sclk_o = ~cfg_sel_i & spi_sclk_i;
    assign adc_mosi_o = ~cfg_sel_i & spi_mosi_i;
endmodule

// File: rtl/cfgspi_chk.sv
module cfgspi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       flag_rearm_o,
    input logic       pbus_wr_o,
    input logic       pbus_rd_o,
    input logic [6:0] pbus_addr_o,
    input logic [9:0] presamples_o,
    input logic [6:0] led_o
);
    a_r6_rearm_single: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rearm_o |=> !flag_rearm_o);

    a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_rd_o |=> !pbus_rd_o);

    a_r8_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_wr_o |=> !pbus_wr_o);

    a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pbus_wr_o && pbus_rd_o));

    a_r8_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_wr_o |-> $stable(pbus_addr_o));

    a_r1_presamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(presamples_o));

    a_r1_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(led_o));
endmodule

bind cfgspi_top cfgspi_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_stb       (wr_stb),
    .flag_rearm_o (flag_rearm_o),
    .pbus_wr_o    (pbus_wr_o),
    .pbus_rd_o    (pbus_rd_o),
    .pbus_addr_o  (pbus_addr_o),
    .presamples_o (presamples_o),
    .led_o        (led_o)
);

// File: tb/cfgspi_top_tb_top.sv
module cfgspi_top_tb_top;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sel = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic adc_sclk, adc_cs_n, adc_mosi;
    logic adc_miso = 1'b0;
    logic [11:0] freq_count = '0;
    logic [1:0]  tp_flags = '0;
    logic [9:0]  presamples;
    logic [2:0]  size_code;
    logic [6:0]  led;
    logic [1:0]  tp_send;
    logic        rearm;
    logic [6:0]  pb_addr;
    logic        pb_wr, pb_rd;
    logic [7:0]  pb_wdata, pb_rdata;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfgspi_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_sel_i(cfg_sel),
        .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi), .spi_miso_o(miso),
        .adc_sclk_o(adc_sclk), .adc_cs_n_o(adc_cs_n), .adc_mosi_o(adc_mosi), .adc_miso_i(adc_miso),
        .freq_count_i(freq_count), .tp_flags_i(tp_flags),
        .presamples_o(presamples), .size_code_o(size_code), .led_o(led), .tp_send_o(tp_send),
        .flag_rearm_o(rearm), .pbus_addr_o(pb_addr), .pbus_wr_o(pb_wr), .pbus_rd_o(pb_rd),
        .pbus_wdata_o(pb_wdata), .pbus_rdata_i(pb_rdata)
    );

    // indirect device model
    function automatic logic [7:0] dev_init(logic [6:0] a);
        return 8'({1'b0, a} * 8'd29 + 8'h3B);
    endfunction

    logic [7:0]   mem [128];
    logic [127:0] mem_v = '0;
    int wr_cnt = 0, rd_cnt = 0, rearm_cnt = 0;
    logic [6:0] last_wa = '0;
    logic [7:0] last_wd = '0;

    assign pb_rdata = mem_v[pb_addr] ? mem[pb_addr] : dev_init(pb_addr);

    always @(posedge clk) begin
        if (pb_wr) begin
            mem[pb_addr]   <= pb_wdata;
            mem_v[pb_addr] <= 1'b1;
            wr_cnt  <= wr_cnt + 1;
            last_wa <= pb_addr;
            last_wd <= pb_wdata;
        end
        if (pb_rd) rd_cnt <= rd_cnt + 1;
        if (rearm) rearm_cnt <= rearm_cnt + 1;
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic frame(input logic [15:0] w, input int nbits, output logic [15:0] r);
        r = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = w[15-i];
            repeat (HP) @(negedge clk);
            r = {r[14:0], miso};
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        logic [15:0] r;
        frame({a, 1'b1, d}, 16, r);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] r);
        frame({a, 1'b0, 12'h000}, 16, r);
    endtask

    function automatic logic [11:0] fmask(int a);
        case (a)
            0: return 12'h3FF;
            1: return 12'h007;
            2: return 12'h07F;
            default: return 12'h003;
        endcase
    endfunction

    function automatic logic [11:0] field_now(int a);
        case (a)
            0: return 12'(presamples);
            1: return 12'(size_code);
            2: return 12'(led);
            default: return 12'(tp_send);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        int w0, r0, k0;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10", "presamples", 32'(presamples), 0);
        check("R10", "size", 32'(size_code), 0);
        check("R10", "led", 32'(led), 0);
        check("R10", "tp_send", 32'(tp_send), 0);
        check("R10", "pbus_addr", 32'(pb_addr), 0);
        check("R10", "strobes", 32'({pb_wr, pb_rd, rearm}), 0);
        check("R10", "miso", 32'(miso), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 / R2 directed: upper bits dropped and read back as zero
        wr(3'd0, 12'hFFF);
        check("R1", "presamples all ones", 32'(presamples), 32'h3FF);
        rd(3'd0, r);
        check("R2", "reg0 read frame", 32'(r), 32'h03FF);
        wr(3'd2, 12'hA55);
        check("R1", "led", 32'(led), 32'h55);
        rd(3'd2, r);
        check("R2", "reg2 read frame", 32'(r), 32'h0055);

        // R1 / R2 random
        for (int i = 0; i < 40; i++) begin
            int a;
            logic [11:0] d;
            a = int'($urandom % 4);
            d = 12'($urandom);
            wr(3'(a), d);
            check("R1", "field after write", 32'(field_now(a)), 32'(d & fmask(a)));
            rd(3'(a), r);
            check("R2", "read back", 32'(r), 32'(d & fmask(a)));
        end

        // R5 status registers
        freq_count = 12'hABC;
        tp_flags = 2'b10;
        rd(3'd4, r);
        check("R5", "freq count read", 32'(r), 32'h0ABC);
        rd(3'd5, r);
        check("R5", "flags read", 32'(r), 32'h0002);
        k0 = 32'(presamples);
        wr(3'd4, 12'h123);
        rd(3'd4, r);
        check("R5", "reg4 after write", 32'(r), 32'h0ABC);
        check("R5", "presamples untouched", 32'(presamples), k0);

        // R6 re-arm pulse
        k0 = rearm_cnt;
        wr(3'd5, 12'h000);
        check("R6", "rearm pulses after write", rearm_cnt - k0, 1);
        k0 = rearm_cnt;
        rd(3'd5, r);
        check("R6", "rearm pulses after read", rearm_cnt - k0, 0);

        // R7 / R9 indirect read
        r0 = rd_cnt;
        wr(3'd6, 12'h05A);
        check("R7", "read strobes", rd_cnt - r0, 1);
        check("R7", "pbus addr", 32'(pb_addr), 32'h5A);
        rd(3'd6, r);
        check("R7", "reg6 read back", 32'(r), 32'h005A);
        rd(3'd7, r);
        check("R9", "captured data", 32'(r), 32'(dev_init(7'h5A)));

        // R8 indirect write
        r0 = rd_cnt;
        w0 = wr_cnt;
        wr(3'd6, 12'h0A3);
        check("R8", "no read strobe with dir=1", rd_cnt - r0, 0);
        rd(3'd6, r);
        check("R7", "reg6 dir read back", 32'(r), 32'h00A3);
        wr(3'd7, 12'h7C4);
        check("R8", "write strobes", wr_cnt - w0, 1);
        check("R8", "write addr", 32'(last_wa), 32'h23);
        check("R8", "write data", 32'(last_wd), 32'hC4);
        wr(3'd6, 12'h023);
        rd(3'd7, r);
        check("R9", "read after write", 32'(r), 32'h00C4);
        w0 = wr_cnt;
        wr(3'd7, 12'h0FF);
        check("R8", "no write strobe with dir=0", wr_cnt - w0, 0);

        // R8 / R9 random indirect
        for (int i = 0; i < 12; i++) begin
            logic [6:0] a;
            logic [7:0] d;
            a = 7'($urandom);
            d = 8'($urandom);
            wr(3'd6, {4'h0, 1'b1, a});
            wr(3'd7, {4'h5, d});
            check("R8", "random write data", 32'(last_wd), 32'(d));
            wr(3'd6, {4'h0, 1'b0, a});
            rd(3'd7, r);
            check("R9", "random read back", 32'(r), 32'(d));
        end

        // R3 cut-short frame
        wr(3'd0, 12'h111);
        w0 = rearm_cnt;
        frame({3'd0, 1'b1, 12'h2EE}, 10, r);
        check("R3", "presamples after short frame", 32'(presamples), 32'h111);
        frame({3'd5, 1'b1, 12'h000}, 15, r);
        check("R3", "no rearm after 15 bits", rearm_cnt - w0, 0);
        wr(3'd0, 12'h2EE);
        check("R3", "full frame after short", 32'(presamples), 32'h2EE);

        // R4 pass-through
        cfg_sel = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b0; sclk = 1'b1; mosi = 1'b1; adc_miso = 1'b1;
        @(negedge clk);
        check("R4", "adc lines follow", 32'({adc_cs_n, adc_sclk, adc_mosi}), 32'b011);
        check("R4", "miso from adc", 32'(miso), 1);
        cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; adc_miso = 1'b0;
        @(negedge clk);
        check("R4", "adc lines idle", 32'({adc_cs_n, adc_sclk, adc_mosi}), 32'b100);
        wr(3'd0, 12'h055);
        check("R4", "no decode in pass-through", 32'(presamples), 32'h2EE);
        cfg_sel = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0; sclk = 1'b1; mosi = 1'b1;
        @(negedge clk);
        check("R4", "adc parked", 32'({adc_cs_n, adc_sclk, adc_mosi}), 32'b100);
        cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
        repeat (HP) @(negedge clk);
        wr(3'd1, 12'h006);
        check("R4", "decode back on", 32'(size_code), 32'h6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule